// File: doc/BRIEF.md
# Cache RAM Power Sequencer

This block controls RAM array power for two caches. Cache 0 is the instruction cache and cache 1 is the data cache. Each cache has its own four-state machine: on, draining, off and waking.

The surrounding logic sends in four things for each cache:
- power-down and power-up requests,
- the cache's enable bit from the control register,
- a flag that says the cache holds no valid entries,
- requests to run a maintenance operation or to re-enable the cache.

The block drives three things back for each cache:
- a RAM power-enable,
- a ready level,
- a one-cycle refusal pulse.

It also drives a stall and a grant for each maintenance request and for each enable request.

The rules are these. A power-down is accepted only when the cache is disabled and empty. Any maintenance or enable request aimed at a cache that is not fully powered is stalled. That request proceeds on its own once a power-up has brought the cache back to the on state. Each transition state lasts a number of cycles set by the `trans_cycles` input, normally 4. The count is captured when the transition starts.

Top module: `cache_ram_pwr_ctrl`

## Requirements
- R1: After reset every cache is in the on state, with `ram_pwr_en` and `pwr_ready` high and `pd_err` low.
- R2: A `pd_req` in the on state with `cache_en` low and `cache_empty` high is accepted. From the next cycle `ram_pwr_en` and `pwr_ready` are low.
- R3: A `pd_req` in the on state with `cache_en` high or `cache_empty` low is refused. `pd_err` is high for exactly the next cycle, and the cache stays powered and ready.
- R4: The draining state lasts T cycles, where T is `trans_cycles` sampled at acceptance and a value of 0 counts as 1. The cache then enters off, with `ram_pwr_en` low.
- R5: A `pu_req` in the off state raises `ram_pwr_en` from the next cycle, with `pwr_ready` still low. After T cycles the cache enters on, and `pwr_ready` rises only at that point.
- R6: A `pu_req` outside the off state and a `pd_req` outside the on state have no effect on any output.
- R7: A `maint_req` to a cache that is not on gives `maint_stall` high and `maint_grant` low. In the on state it gives `maint_grant` high and `maint_stall` low.
- R8: An `enable_req` follows the same stall and grant rule through `enable_stall` and `enable_grant`.
- R9: Requests to one cache never change the outputs of the other cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trans_cycles | input | CNT_W | Transition length in cycles (0 acts as 1) |
| pd_req | input | N_CACHE | Power-down request per cache |
| pu_req | input | N_CACHE | Power-up request per cache |
| cache_en | input | N_CACHE | Cache enable bit from the control register |
| cache_empty | input | N_CACHE | Cache holds no valid entries |
| maint_req | input | N_CACHE | Maintenance operation request, held until granted |
| enable_req | input | N_CACHE | Cache re-enable request, held until granted |
| ram_pwr_en | output | N_CACHE | RAM power enable |
| pwr_ready | output | N_CACHE | Cache fully powered (on state) |
| pd_err | output | N_CACHE | One-cycle refusal of a power-down |
| maint_stall | output | N_CACHE | Maintenance request held off |
| maint_grant | output | N_CACHE | Maintenance request may proceed |
| enable_stall | output | N_CACHE | Enable request held off |
| enable_grant | output | N_CACHE | Enable request may proceed |

## Verification
Some rules are checked by assertions on every cycle:
- a drain only ever starts from a disabled, empty cache,
- a refusal pulse always follows a rule-breaking request,
- off is reached only through draining, and on only through waking,
- no grant is given while the RAMs lack power,
- the transition timer never runs from a zero count.

Other behaviour only the bench's scenarios can show. This covers the exact length of each transition for the lengths 4, 0 and 7, release of a held request exactly when waking completes, ignored requests in the wrong state, and the two caches staying apart. The bench compares all of these against its reference model on every clock.

// File: rtl/cram_pwr_pkg.sv
package cram_pwr_pkg;
  typedef enum logic [1:0] {
    PS_ON    = 2'd0,
    PS_DRAIN = 2'd1,
    PS_OFF   = 2'd2,
    PS_WAKE  = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/cram_trans_timer.sv
module cram_trans_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = (len == '0) ? ONE : len;
    end else if (run && (cnt_q > ONE)) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load || run) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = run && (cnt_q <= ONE);

  // R4
  timer_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q != '0));
endmodule

// File: rtl/cram_pwr_fsm.sv
module cram_pwr_fsm
  import cram_pwr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] trans_cycles,
  input  logic             pd_req,
  input  logic             pu_req,
  input  logic             cache_en,
  input  logic             cache_empty,
  output pwr_state_e       state,
  output logic             ram_pwr_en,
  output logic             pd_err
);
  pwr_state_e st_q, st_d;
  logic       err_q, err_d;
  logic       pd_ok;
  logic       t_load, t_run, t_done;

  assign pd_ok  = !cache_en && cache_empty;
  assign t_load = ((st_q == PS_ON) && pd_req && pd_ok) ||
                  ((st_q == PS_OFF) && pu_req);
  assign t_run  = (st_q == PS_DRAIN) || (st_q == PS_WAKE);

  cram_trans_timer #(.CNT_W(CNT_W)) i_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (t_load),
    .run  (t_run),
    .len  (trans_cycles),
    .done (t_done)
  );

  always_comb begin
    st_d  = st_q;
    err_d = 1'b0;
    unique case (st_q)
      PS_ON: begin
        if (pd_req) begin
          if (pd_ok) st_d  = PS_DRAIN;
          else       err_d = 1'b1;
        end
      end
      PS_DRAIN: if (t_done) st_d = PS_OFF;
      PS_OFF:   if (pu_req) st_d = PS_WAKE;
      PS_WAKE:  if (t_done) st_d = PS_ON;
      default:  st_d = PS_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_ON;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
    end
  end

  assign state      = st_q;
  assign ram_pwr_en = (st_q == PS_ON) || (st_q == PS_WAKE);
  assign pd_err     = err_q;

  // R2
  drain_entry_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_DRAIN && $past(st_q) == PS_ON) |-> $past(!cache_en && cache_empty));

  // R3
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($past(pd_req) && $past(st_q) == PS_ON && $past(cache_en || !cache_empty)));

  // R3
  err_stays_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (st_q == PS_ON));

  // R4
  off_from_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_OFF && $past(st_q) != PS_OFF) |-> ($past(st_q) == PS_DRAIN));

  // R5
  on_from_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_ON && $past(st_q) != PS_ON) |-> ($past(st_q) == PS_WAKE));
endmodule

// File: rtl/cram_access_gate.sv
module cram_access_gate
  import cram_pwr_pkg::*;
(
  input  pwr_state_e state,
  input  logic       maint_req,
  input  logic       enable_req,
  output logic       pwr_ready,
  output logic       maint_stall,
  output logic       maint_grant,
  output logic       enable_stall,
  output logic       enable_grant
);
  logic is_on;

  assign is_on        = (state == PS_ON);
  assign pwr_ready    = is_on;
  assign maint_grant  = maint_req && is_on;
  assign maint_stall  = maint_req && !is_on;
  assign enable_grant = enable_req && is_on;
  assign enable_stall = enable_req && !is_on;
endmodule

// File: rtl/cache_ram_pwr_ctrl.sv
module cache_ram_pwr_ctrl
  import cram_pwr_pkg::*;
#(
  parameter int N_CACHE = 2,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   trans_cycles,
  input  logic [N_CACHE-1:0] pd_req,
  input  logic [N_CACHE-1:0] pu_req,
  input  logic [N_CACHE-1:0] cache_en,
  input  logic [N_CACHE-1:0] cache_empty,
  input  logic [N_CACHE-1:0] maint_req,
  input  logic [N_CACHE-1:0] enable_req,
  output logic [N_CACHE-1:0] ram_pwr_en,
  output logic [N_CACHE-1:0] pwr_ready,
  output logic [N_CACHE-1:0] pd_err,
  output logic [N_CACHE-1:0] maint_stall,
  output logic [N_CACHE-1:0] maint_grant,
  output logic [N_CACHE-1:0] enable_stall,
  output logic [N_CACHE-1:0] enable_grant
);
  for (genvar c = 0; c < N_CACHE; c++) begin : g_cache
    pwr_state_e st;

    cram_pwr_fsm #(.CNT_W(CNT_W)) i_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .trans_cycles(trans_cycles),
      .pd_req      (pd_req[c]),
      .pu_req      (pu_req[c]),
      .cache_en    (cache_en[c]),
      .cache_empty (cache_empty[c]),
      .state       (st),
      .ram_pwr_en  (ram_pwr_en[c]),
      .pd_err      (pd_err[c])
    );

    cram_access_gate i_gate (
      .state       (st),
      .maint_req   (maint_req[c]),
      .enable_req  (enable_req[c]),
      .pwr_ready   (pwr_ready[c]),
      .maint_stall (maint_stall[c]),
      .maint_grant (maint_grant[c]),
      .enable_stall(enable_stall[c]),
      .enable_grant(enable_grant[c])
    );

    // R7
    maint_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      maint_grant[c] |-> ram_pwr_en[c]);

    // R8
    enable_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enable_grant[c] |-> (ram_pwr_en[c] && !enable_stall[c]));

    // R5
    ready_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_ready[c] |-> ram_pwr_en[c]);
  end
endmodule

// File: tb/test_cache_ram_pwr_ctrl.sv
module test_cache_ram_pwr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 2;
  localparam int CW = 4;
  localparam int WATCHDOG = 5000;

  logic          clk;
  logic          rst_n;
  logic [CW-1:0] trans_cycles;
  logic [N-1:0]  pd_req, pu_req, cache_en, cache_empty, maint_req, enable_req;
  logic [N-1:0]  ram_pwr_en, pwr_ready, pd_err;
  logic [N-1:0]  maint_stall, maint_grant, enable_stall, enable_grant;

  cache_ram_pwr_ctrl #(.N_CACHE(N), .CNT_W(CW)) i_cache_ram_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .trans_cycles(trans_cycles),
    .pd_req(pd_req), .pu_req(pu_req), .cache_en(cache_en),
    .cache_empty(cache_empty), .maint_req(maint_req), .enable_req(enable_req),
    .ram_pwr_en(ram_pwr_en), .pwr_ready(pwr_ready), .pd_err(pd_err),
    .maint_stall(maint_stall), .maint_grant(maint_grant),
    .enable_stall(enable_stall), .enable_grant(enable_grant)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  int    cycles   = 0;
  string scen     = "R1";

  // model: 0 on, 1 draining, 2 off, 3 waking
  int m_st  [N];
  int m_cnt [N];
  bit m_err [N];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_fails++;
      $display("FAIL watchdog R1: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  task automatic cmp(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s (scenario %s) t=%0t: actual %b expected %b", tag, scen, $time, act, exp);
    end
  endtask

  task automatic check_outputs();
    logic [N-1:0] e_pw, e_rdy, e_err, e_ms, e_mg, e_es, e_eg;
    for (int c = 0; c < N; c++) begin
      e_pw[c]  = (m_st[c] == 0) || (m_st[c] == 3);
      e_rdy[c] = (m_st[c] == 0);
      e_err[c] = m_err[c];
      e_ms[c]  = maint_req[c] && (m_st[c] != 0);
      e_mg[c]  = maint_req[c] && (m_st[c] == 0);
      e_es[c]  = enable_req[c] && (m_st[c] != 0);
      e_eg[c]  = enable_req[c] && (m_st[c] == 0);
    end
    cmp("R4 ram_pwr_en", ram_pwr_en, e_pw);
    cmp("R5 pwr_ready", pwr_ready, e_rdy);
    cmp("R3 pd_err", pd_err, e_err);
    cmp("R7 maint_stall", maint_stall, e_ms);
    cmp("R7 maint_grant", maint_grant, e_mg);
    cmp("R8 enable_stall", enable_stall, e_es);
    cmp("R8 enable_grant", enable_grant, e_eg);
  endtask

  task automatic model_step();
    int len;
    len = (trans_cycles == 0) ? 1 : int'(trans_cycles);
    for (int c = 0; c < N; c++) begin
      m_err[c] = 1'b0;
      case (m_st[c])
        0: if (pd_req[c]) begin
             if (!cache_en[c] && cache_empty[c]) begin m_st[c] = 1; m_cnt[c] = len; end
             else m_err[c] = 1'b1;
           end
        1: if (m_cnt[c] <= 1) m_st[c] = 2; else m_cnt[c]--;
        2: if (pu_req[c]) begin m_st[c] = 3; m_cnt[c] = len; end
        default: if (m_cnt[c] <= 1) m_st[c] = 0; else m_cnt[c]--;
      endcase
    end
  endtask

  task automatic tick();
    #1;
    check_outputs();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic clear_pulses();
    pd_req = '0;
    pu_req = '0;
  endtask

  initial begin
    rst_n = 1'b0; trans_cycles = CW'(4);
    pd_req = '0; pu_req = '0; cache_en = '1; cache_empty = '0;
    maint_req = '0; enable_req = '0;
    for (int c = 0; c < N; c++) begin m_st[c] = 0; m_cnt[c] = 0; m_err[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    scen = "R1";
    idle(2);

    // R3: refused power-downs (enabled, then non-empty)
    scen = "R3";
    pd_req[0] = 1'b1; tick(); clear_pulses(); idle(2);
    cache_en[0] = 1'b0; pd_req[0] = 1'b1; tick(); clear_pulses(); idle(2);
    cache_empty[1] = 1'b1; pd_req[1] = 1'b1; tick(); clear_pulses(); idle(1);

    // R2/R4: accepted drain of cache 0 with maintenance held; R9 cache 1 untouched
    scen = "R2";
    cache_empty[0] = 1'b1; pd_req[0] = 1'b1; tick(); clear_pulses();
    maint_req[0] = 1'b1;
    scen = "R6";
    pu_req[0] = 1'b1; tick(); clear_pulses();
    pd_req[0] = 1'b1; tick(); clear_pulses();
    scen = "R9";
    maint_req[1] = 1'b1; idle(4); maint_req[1] = 1'b0;

    // R6: off state ignores pd_req; R8 enable stalled
    scen = "R6";
    pd_req[0] = 1'b1; tick(); clear_pulses();
    enable_req[0] = 1'b1; idle(3);

    // R5: wake with held requests released at on entry
    scen = "R5";
    pu_req[0] = 1'b1; tick(); clear_pulses();
    pu_req[0] = 1'b1; tick(); clear_pulses();
    idle(6);
    maint_req[0] = 1'b0; enable_req[0] = 1'b0; idle(1);

    // R4: zero length on cache 1, both caches concurrently
    scen = "R4";
    trans_cycles = '0;
    cache_en[1] = 1'b0;
    pd_req = 2'b11; tick(); clear_pulses();
    idle(6);
    pu_req = 2'b10; tick(); clear_pulses();
    idle(3);

    // R5: long length 7 on cache 0
    scen = "R5";
    trans_cycles = CW'(7);
    pu_req[0] = 1'b1; enable_req[0] = 1'b1; tick(); clear_pulses();
    idle(10);
    enable_req[0] = 1'b0;

    // R8 / R9: drain cache 1 with length 7 while cache 0 serves
    scen = "R8";
    pd_req[1] = 1'b1; tick(); clear_pulses();
    enable_req = 2'b11; maint_req[0] = 1'b1; idle(9);
    pu_req[1] = 1'b1; tick(); clear_pulses();
    idle(10);
    enable_req = '0; maint_req = '0; idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule